// File: doc/BRIEF.md
# Lowest-Set-Bit Manipulation Unit

This block changes an N-bit operand around its first 1 bit or its first 0 bit. It can isolate that bit, clear it, set it, or build a mask that reaches up to it. Each result comes from one add or subtract on the operand (`x-1`, `x+1` or `-x`) followed by a bitwise step. No scan loop is used. A direction input chooses where the search starts. When the search starts from the most significant end, the operand is bit-reversed on the way in, the same rightmost transform runs on it, and the result is bit-reversed on the way out.

The `found` output reports whether the operand holds the bit being searched for. Without a correction, some transforms give all ones when no such bit exists. A per-operation fixup handles this: when nothing is found, a parameter selects between forcing the result to zero and keeping the raw arithmetic result. A second parameter chooses how "not found" is detected. The choice is either a full-width compare or the carry/borrow out of a one-bit-wider add. A parameter also selects an optional output register, which holds both the result and the flag.

Top module: `bitscan_xform`

## Requirements
- R1: With the output register present (`REG_OUT`=1, the default), `result` and `found` are zero while `rst_n` is low.
- R2: Opcode 1 (isolate first 1) gives `x & -x`: a one-hot vector at the first set bit.
- R3: Opcode 2 (clear first 1) gives `x & (x-1)`, so the result has exactly one set bit fewer than the operand.
- R4: Opcode 3 (fill below first 1) gives `x | (x-1)`.
- R5: Opcode 4 (mask up to and including first 1) gives `x ^ (x-1)`. Opcode 5 (mask of trailing zeros) gives `~x & (x-1)`.
- R6: Opcode 6 (set first 0) gives `x | (x+1)`, so the result has one set bit more than the operand. Opcode 7 (isolate first 0) gives `~x & (x+1)`, which is one-hot.
- R7: Opcode 8 (clear trailing ones) gives `x & (x+1)`. Opcode 9 (mask up to and including first 0) gives `x ^ (x+1)`.
- R8: When `from_left` is 1, the search starts at bit N-1 and moves downward. Every opcode then gives the bit-mirror of its rightward result on the mirrored operand.
- R9: `found` is high for opcodes 1–5 when the operand has a 1 bit, and for opcodes 6–9 when it has a 0 bit. When `found` is low and `NOTFOUND_ZERO`=1 (the default), `result` is all zeros.
- R10: Opcodes 0 and 10–15 pass the operand to `result` unchanged, with `found` high.
- R11: With `REG_OUT`=1, `result` and `found` change only at a rising clock edge and show the inputs present at that edge. The result is valid one cycle after the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset for the output register |
| operand | input | WIDTH | Value to transform |
| opcode | input | 4 | Operation select (see R2–R7, R10) |
| from_left | input | 1 | 1: search from the most significant bit |
| result | output | WIDTH | Transformed value |
| found | output | 1 | The searched-for bit exists in the operand |

## Verification
The embedded assertions check these properties on every cycle, on the combinational result before the register:
- the isolate results stay one-hot or zero;
- clearing the first 1 removes exactly one bit, and setting the first 0 adds exactly one bit;
- a pass-through opcode leaves the operand untouched;
- a failed search yields zero;
- a leftward isolate picks the highest set bit.

Only the bench scenarios can show the following:
- exact bit-for-bit results for every opcode and direction against a loop-based reference;
- the reset value;
- the one-cycle latency and hold behaviour of the register.

// File: rtl/bsx_pkg.sv
package bsx_pkg;

  typedef enum logic [3:0] {
    OP_PASS  = 4'd0,
    OP_ISO1  = 4'd1,
    OP_CLR1  = 4'd2,
    OP_FILL1 = 4'd3,
    OP_MSK1  = 4'd4,
    OP_TZM   = 4'd5,
    OP_SET0  = 4'd6,
    OP_ISO0  = 4'd7,
    OP_CLRT  = 4'd8,
    OP_MSK0  = 4'd9
  } bsx_op_e;

  // Opcodes that look for a 1 bit
  function automatic logic seeks_one(input logic [3:0] op);
    return (op >= 4'd1) && (op <= 4'd5);
  endfunction

  // Opcodes that look for a 0 bit
  function automatic logic seeks_zero(input logic [3:0] op);
    return (op >= 4'd6) && (op <= 4'd9);
  endfunction

endpackage

// File: rtl/bsx_reverse.sv
module bsx_reverse #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] din,
  input  logic             flip,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] mirrored;

  for (genvar i = 0; i < WIDTH; i++) begin : g_mirror
    assign mirrored[i] = din[WIDTH-1-i];
  end

  assign dout = flip ? mirrored : din;

endmodule

// File: rtl/bsx_core.sv
module bsx_core
  import bsx_pkg::*;
#(
  parameter int WIDTH      = 16,
  parameter bit CARRY_FLAG = 1'b1
) (
  input  logic [WIDTH-1:0] x,
  input  logic [3:0]       op,
  output logic [WIDTH-1:0] raw,
  output logic             found
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] dec;
  logic [WIDTH-1:0] inc;
  logic [WIDTH-1:0] neg;
  logic             none_one;
  logic             none_zero;

  assign neg = ~x + 1'b1;

  if (CARRY_FLAG) begin : g_carry
    // One extra bit: borrow out of x-1 means x was zero, carry out of x+1 means all ones
    logic [WIDTH:0] dec_ext;
    logic [WIDTH:0] inc_ext;
    assign dec_ext   = {1'b0, x} - 1'b1;
    assign inc_ext   = {1'b0, x} + 1'b1;
    assign dec       = dec_ext[WIDTH-1:0];
    assign inc       = inc_ext[WIDTH-1:0];
    assign none_one  = dec_ext[WIDTH];
    assign none_zero = inc_ext[WIDTH];
  end else begin : g_compare
    assign dec       = x - 1'b1;
    assign inc       = x + 1'b1;
    assign none_one  = (x == '0);
    assign none_zero = (x == ALL_ONES);
  end

  always_comb begin
    case (op)
      OP_ISO1:  raw = x & neg;
      OP_CLR1:  raw = x & dec;
      OP_FILL1: raw = x | dec;
      OP_MSK1:  raw = x ^ dec;
      OP_TZM:   raw = ~x & dec;
      OP_SET0:  raw = x | inc;
      OP_ISO0:  raw = ~x & inc;
      OP_CLRT:  raw = x & inc;
      OP_MSK0:  raw = x ^ inc;
      default:  raw = x;
    endcase
  end

  always_comb begin
    if (seeks_one(op))       found = ~none_one;
    else if (seeks_zero(op)) found = ~none_zero;
    else                     found = 1'b1;
  end

endmodule

// File: rtl/bsx_outreg.sv
module bsx_outreg #(
  parameter int WIDTH  = 16,
  parameter bit ENABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_res,
  input  logic             d_found,
  output logic [WIDTH-1:0] q_res,
  output logic             q_found
);

  if (ENABLE) begin : g_reg
    logic [WIDTH-1:0] res_q, res_d;
    logic             fnd_q, fnd_d;

    always_comb begin
      res_d = d_res;
      fnd_d = d_found;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= '0;
        fnd_q <= 1'b0;
      end else begin
        res_q <= res_d;
        fnd_q <= fnd_d;
      end
    end

    assign q_res   = res_q;
    assign q_found = fnd_q;
  end else begin : g_wire
    assign q_res   = d_res;
    assign q_found = d_found;
  end

endmodule

// File: rtl/bitscan_xform.sv
module bitscan_xform
  import bsx_pkg::*;
#(
  parameter int WIDTH         = 16,
  parameter bit REG_OUT       = 1'b1,
  parameter bit NOTFOUND_ZERO = 1'b1,
  parameter bit CARRY_FLAG    = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] operand,
  input  logic [3:0]       opcode,
  input  logic             from_left,
  output logic [WIDTH-1:0] result,
  output logic             found
);

  logic [WIDTH-1:0] x_in;
  logic [WIDTH-1:0] raw;
  logic [WIDTH-1:0] raw_out;
  logic [WIDTH-1:0] fixed;
  logic             hit;

  bsx_reverse #(.WIDTH(WIDTH)) u_rev_in (
    .din(operand), .flip(from_left), .dout(x_in)
  );

  bsx_core #(.WIDTH(WIDTH), .CARRY_FLAG(CARRY_FLAG)) u_core (
    .x(x_in), .op(opcode), .raw(raw), .found(hit)
  );

  bsx_reverse #(.WIDTH(WIDTH)) u_rev_out (
    .din(raw), .flip(from_left), .dout(raw_out)
  );

  // Not-found fixup
  always_comb begin
    if (!hit && NOTFOUND_ZERO) fixed = '0;
    else                       fixed = raw_out;
  end

  bsx_outreg #(.WIDTH(WIDTH), .ENABLE(REG_OUT)) u_oreg (
    .clk(clk), .rst_n(rst_n),
    .d_res(fixed), .d_found(hit),
    .q_res(result), .q_found(found)
  );

  // Isolate operations produce at most one set bit
  assert_iso_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_ISO1 || opcode == OP_ISO0) |-> $onehot0(fixed));

  // Clearing the first 1 removes exactly one bit and adds none
  assert_clear_drops_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_CLR1 && hit) |->
      (($countones(fixed) + 1 == $countones(operand)) && ((fixed & ~operand) == '0)));

  // Setting the first 0 adds exactly one bit and removes none
  assert_set_adds_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_SET0 && hit) |->
      (($countones(fixed) == $countones(operand) + 1) && ((operand & ~fixed) == '0)));

  // Leftward isolate returns the highest set bit of the operand
  assert_left_iso_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == OP_ISO1 && from_left && hit) |->
      ((operand & ~(fixed | (fixed - 1'b1))) == '0));

  // Failed search forces zero
  assert_notfound_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && NOTFOUND_ZERO) |-> (fixed == '0));

  // Unused codes are transparent
  assert_pass_through_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!seeks_one(opcode) && !seeks_zero(opcode)) |-> (hit && fixed == operand));

endmodule

// File: tb/bitscan_xform_tb.sv
module bitscan_xform_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] operand;
  logic [3:0]   opcode;
  logic         from_left;
  logic [W-1:0] result;
  logic         found;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  bitscan_xform u_dut (
    .clk(clk), .rst_n(rst_n), .operand(operand), .opcode(opcode),
    .from_left(from_left), .result(result), .found(found)
  );

  // Vector layout: {opcode[3:0], from_left, operand[15:0], expected[15:0], expected_found}
  localparam int NV = 17;
  localparam logic [37:0] VEC [0:NV-1] = '{
    {4'd1, 1'b0, 16'h00A8, 16'h0008, 1'b1},  // R2
    {4'd2, 1'b0, 16'h00A8, 16'h00A0, 1'b1},  // R3
    {4'd3, 1'b0, 16'h00A8, 16'h00AF, 1'b1},  // R4
    {4'd4, 1'b0, 16'h00A8, 16'h000F, 1'b1},  // R5
    {4'd5, 1'b0, 16'h00A8, 16'h0007, 1'b1},  // R5
    {4'd6, 1'b0, 16'h00A7, 16'h00AF, 1'b1},  // R6
    {4'd7, 1'b0, 16'h00A7, 16'h0008, 1'b1},  // R6
    {4'd8, 1'b0, 16'h00A7, 16'h00A0, 1'b1},  // R7
    {4'd9, 1'b0, 16'h00A7, 16'h000F, 1'b1},  // R7
    {4'd1, 1'b1, 16'h0A00, 16'h0800, 1'b1},  // R8
    {4'd2, 1'b1, 16'h0A00, 16'h0200, 1'b1},  // R8
    {4'd4, 1'b1, 16'h0100, 16'hFF00, 1'b1},  // R8
    {4'd1, 1'b0, 16'h0000, 16'h0000, 1'b0},  // R9
    {4'd3, 1'b0, 16'h0000, 16'h0000, 1'b0},  // R9
    {4'd6, 1'b0, 16'hFFFF, 16'h0000, 1'b0},  // R9
    {4'd0, 1'b0, 16'h1234, 16'h1234, 1'b1},  // R10
    {4'd15, 1'b1, 16'hBEEF, 16'hBEEF, 1'b1}  // R10
  };

  function automatic string req_of(input logic [3:0] op, input logic dir, input logic f);
    if (!f)  return "R9";
    if (dir) return "R8";
    case (op)
      4'd1:       return "R2";
      4'd2:       return "R3";
      4'd3:       return "R4";
      4'd4, 4'd5: return "R5";
      4'd6, 4'd7: return "R6";
      4'd8, 4'd9: return "R7";
      default:    return "R10";
    endcase
  endfunction

  // Loop reference: region relative to the first matching bit in search order
  function automatic void ref_model(input logic [3:0] op, input logic dir, input logic [W-1:0] x,
                                    output logic [W-1:0] r, output logic f);
    int   kf;
    logic tgt;
    r  = x;
    f  = 1'b1;
    kf = -1;
    if (op < 4'd1 || op > 4'd9) return;
    tgt = (op >= 4'd6) ? 1'b0 : 1'b1;
    for (int k = 0; k < W; k++) begin
      int p = dir ? W-1-k : k;
      if (kf < 0 && x[p] == tgt) kf = k;
    end
    if (kf < 0) begin
      r = '0;
      f = 1'b0;
      return;
    end
    for (int k = 0; k < W; k++) begin
      int p = dir ? W-1-k : k;
      logic below, at;
      below = (k < kf);
      at    = (k == kf);
      case (op)
        4'd1: r[p] = at;
        4'd2: r[p] = at ? 1'b0 : x[p];
        4'd3: r[p] = below ? 1'b1 : x[p];
        4'd4: r[p] = below | at;
        4'd5: r[p] = below;
        4'd6: r[p] = at ? 1'b1 : x[p];
        4'd7: r[p] = at;
        4'd8: r[p] = (below | at) ? 1'b0 : x[p];
        default: r[p] = below | at;
      endcase
    end
  endfunction

  task automatic check(input string tag, input logic [W-1:0] er, input logic ef);
    checks++;
    if (result !== er || found !== ef) begin
      fails++;
      $display("FAIL %s: result=%h found=%b, expected result=%h found=%b", tag, result, found, er, ef);
    end
  endtask

  // Drive at a falling edge, let one rising edge load the register, sample at the next falling edge
  task automatic apply(input logic [3:0] op, input logic dir, input logic [W-1:0] x);
    @(negedge clk);
    opcode    = op;
    from_left = dir;
    operand   = x;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog: cycles=%0d, expected below 100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] er;
    logic         ef;
    logic [W-1:0] pool [0:11];
    rst_n     = 1'b0;
    operand   = 16'h5A5A;
    opcode    = 4'd0;
    from_left = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", '0, 1'b0);  // R1: register clear under reset
    rst_n = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [37:0] v = VEC[i];
      apply(v[37:34], v[33], v[32:17]);
      check(req_of(v[37:34], v[33], v[0]), v[16:1], v[0]);
    end

    // Every opcode and direction against the loop reference
    pool[0] = 16'h0000; pool[1] = 16'hFFFF; pool[2] = 16'h0001; pool[3] = 16'h8000;
    pool[4] = 16'h7FFF; pool[5] = 16'hFFFE; pool[6] = 16'h0010; pool[7] = 16'hFEFF;
    for (int i = 8; i < 12; i++) pool[i] = W'($urandom);
    for (int op = 0; op < 16; op++) begin
      for (int d = 0; d < 2; d++) begin
        for (int i = 0; i < 12; i++) begin
          ref_model(4'(op), d[0], pool[i], er, ef);
          apply(4'(op), d[0], pool[i]);
          check(req_of(4'(op), d[0], ef), er, ef);
        end
        for (int b = 0; b < W; b++) begin
          logic [W-1:0] one = W'(1) << b;
          ref_model(4'(op), d[0], one, er, ef);
          apply(4'(op), d[0], one);
          check(req_of(4'(op), d[0], ef), er, ef);
        end
      end
    end

    // R11: output holds until the next rising edge, then takes the new inputs
    apply(4'd1, 1'b0, 16'h0030);
    check("R11", 16'h0010, 1'b1);
    @(negedge clk);
    opcode  = 4'd2;
    operand = 16'h0030;
    #1;
    check("R11", 16'h0010, 1'b1);
    @(negedge clk);
    check("R11", 16'h0020, 1'b1);

    // R1: asynchronous clear mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", '0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule